// File: doc/BRIEF.md
# Flash Segment Access Control Checker

This block guards a flash array with per-segment access rights. While the core is still held in reset, four 64-bit configuration words arrive on a load port. Two of them are merged by bitwise AND into a privilege-rights register, and the other two into an execute-rights register. Because the words are merged by AND, a second word can only remove rights that the first word granted. When all four words are in, the block raises a core-release output. The rights registers are frozen from then on.

After release, each request on the bus port is checked in its address phase. If the address falls inside the flash window, the block takes the segment number from the top six bits of the flash offset. It then tests the request's privilege and access kind against that segment's two rights bits. An allowed request is forwarded to the flash in the same cycle. A denied request is not forwarded: it is answered one cycle later with an error and zero read data. Addresses outside the flash window are forwarded without any check.

Top module: `flash_seg_guard`

## Requirements
- R1: While reset is high and on the first cycle after it, core_release, fl_req and rsp_valid are all low.
- R2: cfg_sel picks the target word: values 0 and 1 load the privilege-rights register, values 2 and 3 load the execute-rights register. Each register starts all ones in reset and keeps the AND of every word written to it, so a 0 in either word clears that segment's bit.
- R3: core_release goes high one clock after the edge on which the last of the four distinct cfg_sel values is accepted. It then stays high until reset.
- R4: Configuration writes made after core_release is high change no rights.
- R5: A request is in the flash window when addr[31:20] equals the window base. Its segment is addr[19:14], so segment s covers window offsets s*0x4000 to s*0x4000+0x3FFF.
- R6: When a segment's privilege bit is 0, requests with req_super=0 are denied. Requests with req_super=1 are allowed by that bit.
- R7: When a segment's execute bit is 0, data accesses are denied: a read with req_fetch=0, or any request with req_write=1. Instruction fetches (req_fetch=1, req_write=0) are allowed by that bit.
- R8: A denied request does not raise fl_req. On the next cycle rsp_valid=1, rsp_err=1 and rsp_rdata is all zeros.
- R9: An allowed request raises fl_req in the same cycle, with fl_addr and fl_write equal to the request's values. On the next cycle rsp_valid=1, rsp_err=0 and rsp_rdata equals fl_rdata.
- R10: Requests outside the flash window are forwarded as allowed, whatever the rights bits hold.
- R11: Requests made while core_release is low produce neither fl_req nor a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration word strobe |
| cfg_sel | input | 2 | Which of the four words is presented |
| cfg_word | input | 64 | Configuration word, one bit per segment |
| core_release | output | 1 | High once rights are loaded and frozen |
| req_valid | input | 1 | Bus request present |
| req_addr | input | 32 | Request byte address |
| req_super | input | 1 | 1 = supervisor, 0 = user |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| req_write | input | 1 | 1 = write attempt |
| fl_req | output | 1 | Forwarded request to the flash |
| fl_addr | output | 32 | Forwarded address |
| fl_write | output | 1 | Forwarded write flag |
| fl_rdata | input | 32 | Read data from the flash, valid in the response cycle |
| rsp_valid | output | 1 | Response strobe, one cycle after an accepted request |
| rsp_err | output | 1 | Bus error for a denied request |
| rsp_rdata | output | 32 | Returned read data, zero on error |

## Verification
The forward decision (fl_req, fl_addr, fl_write) is combinational and due in the same cycle as the request. rsp_valid, rsp_err and rsp_rdata are due one clock later. core_release is due one clock after the edge that accepts the last configuration word. The bench changes inputs shortly after each rising edge and compares every output at the falling edge against a behavioural model that advances on the rising edge. Each comparison therefore sees the settled result for the current request and the registered result for the previous one. Directed probes at segment edges and on cleared bits add checks whose expected error values were worked out by hand.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int SEG_BITS = 6;
    localparam int NUM_SEG  = 1 << SEG_BITS;

    typedef enum logic [1:0] {
        CFG_PRIV_A = 2'd0,
        CFG_PRIV_B = 2'd1,
        CFG_EXEC_A = 2'd2,
        CFG_EXEC_B = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic super_mode;
        logic fetch;
        logic write;
    } access_t;

    typedef logic [NUM_SEG-1:0] rights_t;

    // Writes and non-fetch reads fall under the data rule.
    function automatic logic is_data(access_t a);
        return a.write || !a.fetch;
    endfunction
endpackage

// File: rtl/fsg_rights_loader.sv
module fsg_rights_loader
    import fsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_valid,
    input  logic [1:0] cfg_sel,
    input  rights_t  cfg_word,
    output rights_t  priv_rights,
    output rights_t  exec_rights,
    output logic     load_done
);
    logic [3:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_rights <= '1;
            exec_rights <= '1;
            seen        <= '0;
            load_done   <= 1'b0;
        end else begin
            if (cfg_valid && !load_done) begin
                if (cfg_sel[1]) exec_rights <= exec_rights & cfg_word;
                else            priv_rights <= priv_rights & cfg_word;
                seen[cfg_sel] <= 1'b1;
            end
            load_done <= load_done | (&seen);
        end
    end

    p_rights_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        load_done |=> ($stable(priv_rights) && $stable(exec_rights)));

    p_release_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        load_done |=> load_done);

    p_only_tighten_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((priv_rights & ~$past(priv_rights)) == '0) &&
                         ((exec_rights & ~$past(exec_rights)) == '0)));
endmodule

// File: rtl/fsg_seg_decode.sv
module fsg_seg_decode
    import fsg_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          FLASH_LOG2 = 20,
    parameter logic [31:0] FLASH_BASE = 32'h1000_0000
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                in_window,
    output logic [SEG_BITS-1:0] seg
);
    localparam int SEG_LSB = FLASH_LOG2 - SEG_BITS;

    logic unused_low;
    assign unused_low = ^addr[SEG_LSB-1:0];

    assign in_window = (addr[ADDR_W-1:FLASH_LOG2] == FLASH_BASE[ADDR_W-1:FLASH_LOG2]);
    assign seg       = addr[FLASH_LOG2-1:SEG_LSB];
endmodule

// File: rtl/fsg_access_judge.sv
module fsg_access_judge
    import fsg_pkg::*;
(
    input  access_t acc,
    input  logic    in_window,
    input  logic    priv_bit,
    input  logic    exec_bit,
    output logic    deny
);
    logic priv_fail, exec_fail;

    assign priv_fail = !acc.super_mode && !priv_bit;
    assign exec_fail = is_data(acc) && !exec_bit;
    assign deny      = in_window && (priv_fail || exec_fail);
endmodule

// File: rtl/flash_seg_guard.sv
module flash_seg_guard
    import fsg_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          FLASH_LOG2 = 20,
    parameter logic [31:0] FLASH_BASE = 32'h1000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [1:0]        cfg_sel,
    input  logic [63:0]       cfg_word,
    output logic              core_release,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_super,
    input  logic              req_fetch,
    input  logic              req_write,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_write,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    rights_t             priv_rights, exec_rights;
    logic                in_window, deny, accepted;
    logic [SEG_BITS-1:0] seg;
    access_t             acc;

    fsg_rights_loader u_loader (
        .clk        (clk),
        .rst        (rst),
        .cfg_valid  (cfg_valid),
        .cfg_sel    (cfg_sel),
        .cfg_word   (cfg_word),
        .priv_rights(priv_rights),
        .exec_rights(exec_rights),
        .load_done  (core_release)
    );

    fsg_seg_decode #(
        .ADDR_W    (ADDR_W),
        .FLASH_LOG2(FLASH_LOG2),
        .FLASH_BASE(FLASH_BASE)
    ) u_decode (
        .addr     (req_addr),
        .in_window(in_window),
        .seg      (seg)
    );

    assign acc = '{super_mode: req_super, fetch: req_fetch, write: req_write};

    fsg_access_judge u_judge (
        .acc      (acc),
        .in_window(in_window),
        .priv_bit (priv_rights[seg]),
        .exec_bit (exec_rights[seg]),
        .deny     (deny)
    );

    assign accepted = req_valid && core_release;
    assign fl_req   = accepted && !deny;
    assign fl_addr  = req_addr;
    assign fl_write = req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= accepted;
            rsp_err   <= accepted && deny;
        end
    end

    assign rsp_rdata = rsp_err ? '0 : fl_rdata;

    p_deny_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (accepted && deny) |-> !fl_req);

    p_err_zero_data_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    p_pass_response_r9: assert property (@(posedge clk) disable iff (rst)
        fl_req |=> (rsp_valid && !rsp_err));

    p_quiet_before_release_r11: assert property (@(posedge clk) disable iff (rst)
        !core_release |-> (!fl_req && !rsp_valid));

    p_outside_passes_r10: assert property (@(posedge clk) disable iff (rst)
        (accepted && !in_window) |-> fl_req);
endmodule

// File: tb/tb_flash_seg_guard.sv
module tb_flash_seg_guard;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_valid = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [63:0] cfg_word = '0;
    logic        core_release;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_super = 1'b0, req_fetch = 1'b0, req_write = 1'b0;
    logic        fl_req, fl_write;
    logic [31:0] fl_addr;
    logic [31:0] fl_rdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    flash_seg_guard dut (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
        .cfg_word(cfg_word), .core_release(core_release), .req_valid(req_valid),
        .req_addr(req_addr), .req_super(req_super), .req_fetch(req_fetch),
        .req_write(req_write), .fl_req(fl_req), .fl_addr(fl_addr),
        .fl_write(fl_write), .fl_rdata(fl_rdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state
    logic [63:0] m_priv = '1, m_exec = '1;
    bit          m_seen[4];
    bit          m_done = 0, m_rv = 0, m_re = 0;

    function automatic bit model_deny(logic [31:0] a, logic s, logic f, logic w);
        int sg;
        if ((a >> 20) != (BASE >> 20)) return 0;
        sg = int'((a >> 14) & 32'h3F);
        if (!s && !m_priv[sg]) return 1;
        if ((w || !f) && !m_exec[sg]) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_priv = '1; m_exec = '1; m_done = 0; m_rv = 0; m_re = 0;
            foreach (m_seen[i]) m_seen[i] = 0;
        end else begin
            bit all_seen;
            all_seen = m_seen[0] && m_seen[1] && m_seen[2] && m_seen[3];
            m_rv = req_valid && m_done;
            m_re = m_rv && model_deny(req_addr, req_super, req_fetch, req_write);
            if (cfg_valid && !m_done) begin
                if (cfg_sel >= 2) m_exec = m_exec & cfg_word;
                else              m_priv = m_priv & cfg_word;
                m_seen[cfg_sel] = 1;
            end
            if (all_seen) m_done = 1;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            bit efl;
            efl = req_valid && m_done && !model_deny(req_addr, req_super, req_fetch, req_write);
            chk("R3 core_release", core_release, m_done);
            chk("R9 fl_req", fl_req, efl);
            if (efl) begin
                chk("R9 fl_addr", fl_addr, req_addr);
                chk("R9 fl_write", fl_write, req_write);
            end
            chk("R9 rsp_valid", rsp_valid, m_rv);
            if (m_rv) begin
                chk("R8 rsp_err", rsp_err, m_re);
                chk("R8 rsp_rdata", rsp_rdata, m_re ? 32'h0 : fl_rdata);
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
        fl_rdata = $urandom;
    endtask

    task automatic load(logic [1:0] sel, logic [63:0] w);
        step();
        cfg_valid = 1; cfg_sel = sel; cfg_word = w;
        step();
        cfg_valid = 0;
    endtask

    task automatic probe(string tag, logic [31:0] a, logic s, logic f, logic w, bit exp_err);
        step();
        req_valid = 1; req_addr = a; req_super = s; req_fetch = f; req_write = w;
        @(negedge clk);
        chk({tag, " forward"}, fl_req, !exp_err);
        step();
        req_valid = 0;
        @(negedge clk);
        chk({tag, " rsp_valid"}, rsp_valid, 1);
        chk({tag, " rsp_err"}, rsp_err, exp_err);
        if (exp_err) chk({tag, " zero data"}, rsp_rdata, 0);
    endtask

    function automatic logic [31:0] seg_addr(int s, int off);
        return BASE + 32'(s * 32'h4000) + 32'(off);
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 release in reset", core_release, 0);
        chk("R1 fl_req in reset", fl_req, 0);
        chk("R1 rsp_valid in reset", rsp_valid, 0);
        step(); rst = 0;
        @(negedge clk);
        chk("R1 release after reset", core_release, 0);
        chk("R1 rsp_valid after reset", rsp_valid, 0);

        // R11: request before release
        step();
        req_valid = 1; req_addr = seg_addr(7, 0); req_super = 1; req_fetch = 1;
        @(negedge clk);
        chk("R11 no forward", fl_req, 0);
        step(); req_valid = 0;
        @(negedge clk);
        chk("R11 no response", rsp_valid, 0);

        // R2 load: priv clears 3 and 40; exec clears 5, 10, 63
        load(2'd0, ~(64'd1 << 3));
        load(2'd2, ~(64'd1 << 5));
        load(2'd1, ~(64'd1 << 40));
        step();
        cfg_valid = 1; cfg_sel = 2'd3; cfg_word = ~((64'd1 << 10) | (64'd1 << 63));
        @(negedge clk);
        chk("R3 low before last edge", core_release, 0);
        step(); cfg_valid = 0;
        @(negedge clk);
        chk("R3 low one edge after last", core_release, 0);
        step();
        @(negedge clk);
        chk("R3 high", core_release, 1);

        probe("R6 user read priv0", seg_addr(3, 16), 0, 0, 0, 1);
        probe("R6 super read priv0", seg_addr(3, 16), 1, 0, 0, 0);
        probe("R2 second priv word", seg_addr(40, 0), 0, 1, 0, 1);
        probe("R2 second exec word", seg_addr(10, 4), 1, 0, 0, 1);
        probe("R7 fetch exec0", seg_addr(5, 8), 1, 1, 0, 0);
        probe("R7 read exec0", seg_addr(5, 8), 1, 0, 0, 1);
        probe("R7 write exec0", seg_addr(5, 8), 1, 0, 1, 1);
        probe("R7 write fetch flag", seg_addr(63, 0), 1, 1, 1, 1);
        probe("R5 last byte seg5", seg_addr(5, 32'h3FFC), 1, 0, 0, 1);
        probe("R5 first byte seg6", seg_addr(6, 0), 0, 0, 0, 0);
        probe("R10 outside window", 32'h2000_0000 + 32'(5 * 32'h4000), 0, 0, 1, 0);

        // R4: late writes ignored
        load(2'd0, 64'd0);
        load(2'd3, 64'd0);
        probe("R4 priv unchanged", seg_addr(6, 0), 0, 0, 0, 0);
        probe("R4 exec unchanged", seg_addr(7, 0), 1, 0, 1, 0);

        // Random traffic against the model
        for (int i = 0; i < 400; i++) begin
            step();
            req_valid = ($urandom % 4) != 0;
            req_addr  = ($urandom % 8 == 0) ? $urandom : seg_addr(int'($urandom % 64), int'($urandom % 32'h4000));
            req_super = $urandom; req_fetch = $urandom; req_write = $urandom;
        end
        step(); req_valid = 0;
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule